// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block connects two byte-wide buses, called A and B, through a transceiver that can forward data in either direction. Each bus has its own storage register. Each port can drive either the live value of the opposite bus or the value stored from that opposite bus. Each port has its own drive enable, and the two enables have opposite polarity. The pads are modelled as separate input, output and output-enable vectors, so the design needs no tri-state logic inside the chip.

The two capture strobes are sampled on the single system clock. A strobe that is high at a rising edge makes its register take in the resolved bus value. The resolved value is what the bus carries: the port's own output when the port drives, and the pad input when it does not. Capture ignores both the selects and the enables. When both ports drive in live mode, each port would echo the other. In that case a keeper register holds the value the A bus had on the cycle before this echo mode began, so the pair keeps its last value whatever the pads carry.

Top module: `dual_reg_xcvr`

## Requirements
- R1: When `a_cap_i` is high at a rising clock edge, register A loads the resolved A bus value, in every enable and select combination; when it is low, register A holds.
- R2: When `b_cap_i` is high at a rising clock edge, register B loads the resolved B bus value, in every enable and select combination; when it is low, register B holds.
- R3: `b_pad_oe` is all ones exactly when `b_drive_en_i` is 1, and `a_pad_oe` is all ones exactly when `a_drive_n_i` is 0; otherwise the vectors are all zeros. A resolved bus equals its pad output when the port drives and its pad input when it does not.
- R4: With `b_drive_en_i`=0 and `a_drive_n_i`=1, neither port drives, and each resolved bus equals its own pad input.
- R5: While B drives, `b_sel_stored_i`=0 puts the live resolved A bus on B, and `b_sel_stored_i`=1 puts the contents of register A on B.
- R6: While A drives, `a_sel_stored_i`=0 puts the live resolved B bus on A, and `a_sel_stored_i`=1 puts the contents of register B on A.
- R7: With both ports driving and both selects at 1, the A bus carries register B and the B bus carries register A at the same time.
- R8: With both ports driving and both selects at 0 (echo mode), both buses carry the A-bus value of the cycle before echo mode began. They keep that value for as long as echo mode lasts, whatever the pad inputs are.
- R9: With both enables high, `b_sel_stored_i`=0 and both strobes high, both registers load the A pad value. With both enables low, `a_sel_stored_i`=0 and both strobes high, both registers load the B pad value.
- R10: A low `rst_n` at a rising edge clears both registers and the keeper to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_pad_i | input | W | Value seen at the A pads |
| a_pad_o | output | W | Value driven onto the A pads (zero when not driving) |
| a_pad_oe | output | W | A pad output enables |
| b_pad_i | input | W | Value seen at the B pads |
| b_pad_o | output | W | Value driven onto the B pads (zero when not driving) |
| b_pad_oe | output | W | B pad output enables |
| a_cap_i | input | 1 | Capture strobe for register A |
| b_cap_i | input | 1 | Capture strobe for register B |
| b_drive_en_i | input | 1 | Active-high enable for driving the B port |
| a_drive_n_i | input | 1 | Active-low enable for driving the A port |
| b_sel_stored_i | input | 1 | B port source: 0 live A bus, 1 register A |
| a_sel_stored_i | input | 1 | A port source: 0 live B bus, 1 register B |

## Verification
The assertions check the following on every cycle: register capture and hold for both strobes, isolation, the live path onto B, the crossed stored paths, the value held steady through echo mode, and the cleared registers after reset. Only the bench's scenarios can show several things. First, that echo mode takes exactly the A value of the cycle before it began. Second, that a dual capture with both enables high or both low really lands the same pad byte in both registers. Third, that stored contents made visible through the stored mode match values captured many cycles earlier under other modes.

// File: rtl/dual_reg_xcvr_pkg.sv
package dual_reg_xcvr_pkg;

  typedef enum logic [2:0] {
    XM_ISOLATE = 3'd0,
    XM_A_TO_B  = 3'd1,
    XM_B_TO_A  = 3'd2,
    XM_ECHO    = 3'd3,
    XM_BOTH    = 3'd4
  } xcvr_mode_e;

  // Classifies the drive configuration; echo is the only cyclic one.
  function automatic xcvr_mode_e classify(input logic b_drv, input logic a_drv,
                                          input logic b_sel, input logic a_sel);
    if (!a_drv && !b_drv)      return XM_ISOLATE;
    if (!a_drv)                return XM_A_TO_B;
    if (!b_drv)                return XM_B_TO_A;
    if (!a_sel && !b_sel)      return XM_ECHO;
    return XM_BOTH;
  endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int  W         = 8,
  parameter bit  HAS_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        if (load_i) q_o <= d_i;
      end
    end
  endgenerate

endmodule

// File: rtl/xcvr_port_mux.sv
module xcvr_port_mux #(
  parameter int W = 8
) (
  input  logic         echo_i,
  input  logic [W-1:0] keep_i,
  input  logic         drv_i,
  input  logic         sel_stored_i,
  input  logic [W-1:0] far_reg_i,
  input  logic         far_drv_i,
  input  logic [W-1:0] near_reg_i,
  input  logic [W-1:0] pad_i,
  input  logic [W-1:0] far_pad_i,
  output logic [W-1:0] bus_o,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o
);

  // Value of the opposite bus when this port drives it live. Outside echo,
  // a driving far side must be in stored mode and so shows this side's register.
  function automatic logic [W-1:0] far_live(input logic fdrv,
                                            input logic [W-1:0] nreg,
                                            input logic [W-1:0] fpad);
    return fdrv ? nreg : fpad;
  endfunction

  logic [W-1:0] drive_val;

  always_comb begin
    if (echo_i)            drive_val = keep_i;
    else if (sel_stored_i) drive_val = far_reg_i;
    else                   drive_val = far_live(far_drv_i, near_reg_i, far_pad_i);
  end

  assign bus_o    = drv_i ? drive_val : pad_i;
  assign pad_o    = drv_i ? drive_val : '0;
  assign pad_oe_o = {W{drv_i}};

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import dual_reg_xcvr_pkg::*;
#(
  parameter int W         = 8,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_pad_i,
  output logic [W-1:0] a_pad_o,
  output logic [W-1:0] a_pad_oe,
  input  logic [W-1:0] b_pad_i,
  output logic [W-1:0] b_pad_o,
  output logic [W-1:0] b_pad_oe,
  input  logic         a_cap_i,
  input  logic         b_cap_i,
  input  logic         b_drive_en_i,
  input  logic         a_drive_n_i,
  input  logic         b_sel_stored_i,
  input  logic         a_sel_stored_i
);

  logic         a_drv, b_drv;
  xcvr_mode_e   mode;
  logic         echo_mode;
  logic [W-1:0] reg_a, reg_b, keep_q;
  logic [W-1:0] a_bus, b_bus;
  logic         a_load, b_load;

  assign a_drv     = ~a_drive_n_i;
  assign b_drv     = b_drive_en_i;
  assign mode      = classify(b_drv, a_drv, b_sel_stored_i, a_sel_stored_i);
  assign echo_mode = (mode == XM_ECHO);
  assign a_load    = a_cap_i;
  assign b_load    = b_cap_i;

  xcvr_port_mux #(.W(W)) u_mux_a (
    .echo_i      (echo_mode),
    .keep_i      (keep_q),
    .drv_i       (a_drv),
    .sel_stored_i(a_sel_stored_i),
    .far_reg_i   (reg_b),
    .far_drv_i   (b_drv),
    .near_reg_i  (reg_a),
    .pad_i       (a_pad_i),
    .far_pad_i   (b_pad_i),
    .bus_o       (a_bus),
    .pad_o       (a_pad_o),
    .pad_oe_o    (a_pad_oe)
  );

  xcvr_port_mux #(.W(W)) u_mux_b (
    .echo_i      (echo_mode),
    .keep_i      (keep_q),
    .drv_i       (b_drv),
    .sel_stored_i(b_sel_stored_i),
    .far_reg_i   (reg_a),
    .far_drv_i   (a_drv),
    .near_reg_i  (reg_b),
    .pad_i       (b_pad_i),
    .far_pad_i   (a_pad_i),
    .bus_o       (b_bus),
    .pad_o       (b_pad_o),
    .pad_oe_o    (b_pad_oe)
  );

  xcvr_store_reg #(.W(W), .HAS_RESET(HAS_RESET)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .load_i(a_load), .d_i(a_bus), .q_o(reg_a)
  );

  xcvr_store_reg #(.W(W), .HAS_RESET(HAS_RESET)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .load_i(b_load), .d_i(b_bus), .q_o(reg_b)
  );

  // Keeper: follows the A bus outside echo and freezes inside it.
  xcvr_store_reg #(.W(W), .HAS_RESET(HAS_RESET)) u_keep (
    .clk(clk), .rst_n(rst_n), .load_i(~echo_mode), .d_i(a_bus), .q_o(keep_q)
  );

endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
  parameter int W         = 8,
  parameter bit HAS_RESET = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a_cap_i,
  input logic         b_cap_i,
  input logic         b_drive_en_i,
  input logic         a_drive_n_i,
  input logic         b_sel_stored_i,
  input logic         a_sel_stored_i,
  input logic [W-1:0] a_pad_i,
  input logic [W-1:0] b_pad_i,
  input logic [W-1:0] a_pad_o,
  input logic [W-1:0] b_pad_o,
  input logic [W-1:0] a_pad_oe,
  input logic [W-1:0] b_pad_oe,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic         echo_mode
);

  assert_cap_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    a_cap_i |=> reg_a == $past(a_bus));
  assert_hold_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !a_cap_i |=> $stable(reg_a));
  assert_cap_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_cap_i |=> reg_b == $past(b_bus));
  assert_hold_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !b_cap_i |=> $stable(reg_b));
  assert_isolate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_drive_en_i && a_drive_n_i) |->
      (a_pad_oe == '0 && b_pad_oe == '0 && a_bus == a_pad_i && b_bus == b_pad_i));
  assert_live_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drive_en_i && !b_sel_stored_i && a_drive_n_i) |-> b_pad_o == a_pad_i);
  assert_cross_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drive_en_i && !a_drive_n_i && b_sel_stored_i && a_sel_stored_i) |->
      (a_pad_o == reg_b && b_pad_o == reg_a));
  assert_echo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    echo_mode |=> (!echo_mode || (a_bus == $past(a_bus) && b_bus == a_bus)));

  generate
    if (HAS_RESET) begin : g_rst_chk
      assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_a == '0 && reg_b == '0));
    end
  endgenerate

endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.W(W), .HAS_RESET(HAS_RESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_cap_i(a_cap_i), .b_cap_i(b_cap_i),
  .b_drive_en_i(b_drive_en_i), .a_drive_n_i(a_drive_n_i),
  .b_sel_stored_i(b_sel_stored_i), .a_sel_stored_i(a_sel_stored_i),
  .a_pad_i(a_pad_i), .b_pad_i(b_pad_i), .a_pad_o(a_pad_o), .b_pad_o(b_pad_o),
  .a_pad_oe(a_pad_oe), .b_pad_oe(b_pad_oe), .a_bus(a_bus), .b_bus(b_bus),
  .reg_a(reg_a), .reg_b(reg_b), .echo_mode(echo_mode)
);

// File: tb/tb_dual_reg_xcvr.sv
module tb_dual_reg_xcvr;

  localparam int W = 8;
  localparam int VW = 28;
  localparam int NV = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_pad_i = '0, b_pad_i = '0;
  logic [W-1:0] a_pad_o, a_pad_oe, b_pad_o, b_pad_oe;
  logic         a_cap_i = 1'b0, b_cap_i = 1'b0;
  logic         b_drive_en_i = 1'b0, a_drive_n_i = 1'b1;
  logic         b_sel_stored_i = 1'b0, a_sel_stored_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model state
  logic [W-1:0] m_ra = '0, m_rb = '0, m_keep = '0;

  always #5 clk = ~clk;

  dual_reg_xcvr #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_pad_i(a_pad_i), .a_pad_o(a_pad_o), .a_pad_oe(a_pad_oe),
    .b_pad_i(b_pad_i), .b_pad_o(b_pad_o), .b_pad_oe(b_pad_oe),
    .a_cap_i(a_cap_i), .b_cap_i(b_cap_i),
    .b_drive_en_i(b_drive_en_i), .a_drive_n_i(a_drive_n_i),
    .b_sel_stored_i(b_sel_stored_i), .a_sel_stored_i(a_sel_stored_i)
  );

  // Fields: ben, adn, bsel, asel, acap, bcap, apad, bpad, requirement
  function automatic logic [VW-1:0] mk(input logic ben, input logic adn,
      input logic bs, input logic as_, input logic ac, input logic bc,
      input logic [7:0] ap, input logic [7:0] bp, input logic [5:0] rq);
    return {ben, adn, bs, as_, ac, bc, ap, bp, rq};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    mk(0,1,0,0,1,1,8'h11,8'h22,6'd4),  // R4 isolation, R1 R2 capture
    mk(1,0,1,1,0,0,8'h33,8'h44,6'd7),  // R7 crossed stored view
    mk(1,1,0,0,1,0,8'h5A,8'hC3,6'd5),  // R5 live A onto B, capture A
    mk(1,1,1,0,0,0,8'h66,8'h77,6'd5),  // R5 stored A onto B
    mk(0,0,0,0,0,1,8'h88,8'h7E,6'd6),  // R6 live B onto A, capture B
    mk(0,0,0,1,0,0,8'h99,8'h01,6'd6),  // R6 stored B onto A
    mk(0,1,1,0,1,1,8'h90,8'h0F,6'd1),  // R1 R2 capture with mixed selects
    mk(1,0,1,1,0,0,8'h00,8'h00,6'd2),  // R2 R7 view stored pair
    mk(1,1,0,1,1,1,8'hC4,8'hEE,6'd9),  // R9 A data into both
    mk(1,0,1,1,0,0,8'h00,8'h00,6'd9),  // R9 view
    mk(0,0,1,0,1,1,8'hDD,8'h3B,6'd9),  // R9 B data into both
    mk(1,0,1,1,0,0,8'h00,8'h00,6'd9),  // R9 view
    mk(0,1,0,0,0,0,8'hA5,8'h5A,6'd3),  // R3 isolation before echo
    mk(1,0,0,0,1,1,8'h00,8'hFF,6'd8),  // R8 echo entry
    mk(1,0,0,0,0,0,8'h12,8'h34,6'd8),  // R8 echo persists
    mk(1,0,1,1,0,0,8'h00,8'h00,6'd8)   // R8 captured keeper view
  };

  // Relaxation model of the two buses; echo resolves to the keeper.
  task automatic model_bus(output logic [W-1:0] ea, output logic [W-1:0] eb);
    logic aon, bon;
    aon = !a_drive_n_i;
    bon = b_drive_en_i;
    if (aon && bon && !a_sel_stored_i && !b_sel_stored_i) begin
      ea = m_keep; eb = m_keep;
    end else begin
      ea = aon ? '0 : a_pad_i;
      eb = bon ? '0 : b_pad_i;
      for (int p = 0; p < 2; p++) begin
        if (aon) ea = a_sel_stored_i ? m_rb : eb;
        if (bon) eb = b_sel_stored_i ? m_ra : ea;
      end
    end
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply at negedge, check mid-cycle, advance model at posedge.
  task automatic step(input logic [VW-1:0] v);
    logic [W-1:0] ea, eb, ra, rb;
    logic echo;
    @(negedge clk);
    {b_drive_en_i, a_drive_n_i, b_sel_stored_i, a_sel_stored_i,
     a_cap_i, b_cap_i, a_pad_i, b_pad_i} = v[VW-1:6];
    #1;
    model_bus(ea, eb);
    ra = a_pad_oe[0] ? a_pad_o : a_pad_i;
    rb = b_pad_oe[0] ? b_pad_o : b_pad_i;
    check($sformatf("R%0d A bus", v[5:0]), ra, ea);
    check($sformatf("R%0d B bus", v[5:0]), rb, eb);
    check("R3 enables", {a_pad_oe, b_pad_oe}, {{W{!a_drive_n_i}}, {W{b_drive_en_i}}});
    echo = !a_drive_n_i && b_drive_en_i && !a_sel_stored_i && !b_sel_stored_i;
    @(posedge clk);
    if (a_cap_i) m_ra = ea;
    if (b_cap_i) m_rb = eb;
    if (!echo) m_keep = ea;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    a_cap_i = 1'b0; b_cap_i = 1'b0;
    repeat (2) @(posedge clk);
    m_ra = '0; m_rb = '0; m_keep = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R10: reset state seen through the crossed stored view and the echo view
    step(mk(1,0,1,1,0,0,8'h55,8'hAA,6'd10));
    step(mk(1,0,0,0,0,0,8'h55,8'hAA,6'd10));
    for (int i = 0; i < NV; i++) step(VEC[i]);
    // R10: reset mid-run clears the non-zero registers
    do_reset();
    step(mk(1,0,1,1,0,0,8'hF0,8'h0F,6'd10));
    // R1: strobe low holds while the bus changes under stored view
    step(mk(0,1,0,0,1,0,8'h3C,8'h00,6'd1));
    step(mk(0,1,0,0,0,0,8'hFF,8'hFF,6'd1));
    step(mk(1,0,1,1,0,0,8'h00,8'h00,6'd1));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule